// File: doc/BRIEF.md
# Stack-Top Arithmetic and Compare Unit

This unit performs the arithmetic and decision operations of a stack-based processor on the words at the top of its data stack. When it is started, the core supplies an operation selector, the current stack pointer and the two uppermost stack words. The unit returns the word to write at the new top, the new stack pointer and a write enable. A start/done handshake lets division and remainder take several cycles. All other operations finish in a single cycle.

Binary operations pop one word. They use the lower of the two words as the left operand and the top word as the right operand, and the result replaces the new top. Unary operations rewrite the top word and leave the stack pointer where it is. A return request is not carried out here: the unit raises a flag so that the core can act on it. A zero divisor and an unknown selector are reported in the same way, through flags. Stack memory access and control flow belong to the core.

Top module: `stack_op_unit`

## Requirements
- R1: After a synchronous reset, `done`, `wr_en`, `ret_flag`, `div_zero` and `illegal` are low, and `result` and `sp_out` are zero.
- R2: Selectors 2 (add), 3 (subtract) and 4 (multiply) give `next_word` op `top_word`, wrapped to DATA_W bits. Multiply keeps the low word of the product. `sp_out` is `sp_in` minus one modulo 2^SP_W, and `wr_en` is high.
- R3: Selector 1 (negate) gives the two's complement of `top_word`, so the most negative value maps to itself. Selector 6 (odd test) gives 1 when `top_word` is odd and 0 otherwise, negative values included. Both keep `sp_out` equal to `sp_in`.
- R4: Selectors 5 (divide) and 7 (remainder) take `next_word` as the dividend and `top_word` as the divisor. The quotient truncates toward zero, and the remainder carries the sign of the dividend. The most negative value divided by -1 wraps to itself. `sp_out` is `sp_in` minus one.
- R5: Selectors 8 (equal), 9 (not equal), 10 (less), 11 (less or equal) and 12 (greater) compare `next_word` with `top_word` as signed values. The result is 1 when the comparison holds and 0 when it does not, and `sp_out` is `sp_in` minus one.
- R6: A divide or remainder with a zero `top_word` raises `div_zero` with `done`. `wr_en` stays low and `sp_out` equals `sp_in`.
- R7: Selector 0 raises `ret_flag` with `done`. `wr_en` stays low and `sp_out` equals `sp_in`.
- R8: Any selector above 12 raises `illegal` with `done`. `wr_en` stays low and `sp_out` equals `sp_in`.
- R9: For every operation except a divide or remainder with a nonzero divisor, `done` rises one cycle after `start` is accepted. A divide or remainder with a nonzero divisor raises `done` within DATA_W+2 cycles of acceptance.
- R10: A `start` that arrives after an accepted start and before its `done` has no effect: no extra `done` appears, and the pending result is not altered.
- R11: `done`, `wr_en` and the three flags last one cycle, and at most one of `wr_en`, `ret_flag`, `div_zero` and `illegal` is high at a time. `result` changes only with `wr_en`, and `sp_out` holds between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to execute the operation on the inputs |
| op_sel | input | OP_W (4) | Operation selector |
| sp_in | input | SP_W | Current stack pointer |
| top_word | input | DATA_W | Word at the stack pointer (right operand) |
| next_word | input | DATA_W | Word just below the top (left operand) |
| done | output | 1 | Completion pulse |
| result | output | DATA_W | Value to write at the new top |
| sp_out | output | SP_W | New stack pointer |
| wr_en | output | 1 | Write `result` at `sp_out`, pulsed with `done` |
| ret_flag | output | 1 | Return operation requested |
| div_zero | output | 1 | Division or remainder by zero |
| illegal | output | 1 | Selector outside the defined set |

## Verification
The bench builds the unit with DATA_W=8 and SP_W=6. With these widths the awkward arithmetic cases can be reached with small literals: add and multiply overflow, negating -128, and -128 divided by -1. The narrow stack pointer lets a pop from zero wrap to 63. An 8-bit divider finishes in about ten cycles, so the bench can issue extra starts throughout a division and then confirm that the division's result and stack pointer come through unchanged.

// File: rtl/stkop_pkg.sv
package stkop_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_RTN = 4'd0,
    OP_NEG = 4'd1,
    OP_ADD = 4'd2,
    OP_SUB = 4'd3,
    OP_MUL = 4'd4,
    OP_DIV = 4'd5,
    OP_ODD = 4'd6,
    OP_MOD = 4'd7,
    OP_EQL = 4'd8,
    OP_NEQ = 4'd9,
    OP_LSS = 4'd10,
    OP_LEQ = 4'd11,
    OP_GTR = 4'd12
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd12;

  function automatic logic op_legal(input logic [OP_W-1:0] s);
    return s <= OP_LAST;
  endfunction

  function automatic logic op_divlike(input logic [OP_W-1:0] s);
    return (s == OP_DIV) || (s == OP_MOD);
  endfunction

  // pops one word: everything legal except return, negate and odd test
  function automatic logic op_pops(input logic [OP_W-1:0] s);
    return op_legal(s) && (s != OP_RTN) && (s != OP_NEG) && (s != OP_ODD);
  endfunction
endpackage

// File: rtl/stkop_alu.sv
module stkop_alu
  import stkop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] value
);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] prod;
  logic signed [DATA_W-1:0] sl, sr;

  assign prod = lhs * rhs;
  assign sl   = $signed(lhs);
  assign sr   = $signed(rhs);

  always_comb begin
    case (op)
      OP_NEG:  value = ZERO - rhs;
      OP_ADD:  value = lhs + rhs;
      OP_SUB:  value = lhs - rhs;
      OP_MUL:  value = prod;
      OP_ODD:  value = rhs[0] ? ONE : ZERO;
      OP_EQL:  value = (lhs == rhs) ? ONE : ZERO;
      OP_NEQ:  value = (lhs != rhs) ? ONE : ZERO;
      OP_LSS:  value = (sl < sr)    ? ONE : ZERO;
      OP_LEQ:  value = (sl <= sr)   ? ONE : ZERO;
      OP_GTR:  value = (sl > sr)    ? ONE : ZERO;
      default: value = ZERO;
    endcase
  end
endmodule

// File: rtl/stkop_divider.sv
module stkop_divider #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              fin,
  output logic [DATA_W-1:0] quot,
  output logic [DATA_W-1:0] remd
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic [DATA_W-1:0] rem_q, quo_q, dvs_q;
  logic              neg_q, neg_r;
  logic [DATA_W:0]   rem_sh, trial;

  assign rem_sh = {rem_q, quo_q[DATA_W-1]};
  assign trial  = rem_sh - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend[DATA_W-1] ? -dividend : dividend;
        dvs_q <= divisor[DATA_W-1] ? -divisor : divisor;
        neg_q <= dividend[DATA_W-1] ^ divisor[DATA_W-1];
        neg_r <= dividend[DATA_W-1];
        cnt   <= CNT_W'(DATA_W);
        run   <= 1'b1;
      end else if (run) begin
        if (!trial[DATA_W]) begin
          rem_q <= trial[DATA_W-1:0];
          quo_q <= {quo_q[DATA_W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh[DATA_W-1:0];
          quo_q <= {quo_q[DATA_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quot = neg_q ? -quo_q : quo_q;
  assign remd = neg_r ? -rem_q : rem_q;
endmodule

// File: rtl/stack_op_unit.sv
module stack_op_unit
  import stkop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SP_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [DATA_W-1:0] top_word,
  input  logic [DATA_W-1:0] next_word,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [SP_W-1:0]   sp_out,
  output logic              wr_en,
  output logic              ret_flag,
  output logic              div_zero,
  output logic              illegal
);
  typedef enum logic {S_IDLE, S_DIV} st_e;

  st_e               st;
  logic              accept, launch, zero_dvs;
  logic              mod_q;
  logic [SP_W-1:0]   sp_hold;
  logic [DATA_W-1:0] fast_val, quot, remd;
  logic              div_fin;

  assign accept   = start && (st == S_IDLE);   // R10
  assign zero_dvs = (top_word == '0);
  assign launch   = accept && op_divlike(op_sel) && !zero_dvs;

  stkop_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (op_sel),
    .lhs   (next_word),
    .rhs   (top_word),
    .value (fast_val)
  );

  stkop_divider #(.DATA_W(DATA_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (launch),
    .dividend (next_word),
    .divisor  (top_word),
    .fin      (div_fin),
    .quot     (quot),
    .remd     (remd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin                             // R1
      st       <= S_IDLE;
      done     <= 1'b0;
      wr_en    <= 1'b0;
      ret_flag <= 1'b0;
      div_zero <= 1'b0;
      illegal  <= 1'b0;
      result   <= '0;
      sp_out   <= '0;
      mod_q    <= 1'b0;
      sp_hold  <= '0;
    end else begin
      done     <= 1'b0;                        // R11 pulses
      wr_en    <= 1'b0;
      ret_flag <= 1'b0;
      div_zero <= 1'b0;
      illegal  <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (!op_legal(op_sel)) begin         // R8
            illegal <= 1'b1;
            done    <= 1'b1;
            sp_out  <= sp_in;
          end else if (op_sel == OP_RTN) begin // R7
            ret_flag <= 1'b1;
            done     <= 1'b1;
            sp_out   <= sp_in;
          end else if (op_divlike(op_sel)) begin
            if (zero_dvs) begin                // R6
              div_zero <= 1'b1;
              done     <= 1'b1;
              sp_out   <= sp_in;
            end else begin                     // R4
              st      <= S_DIV;
              mod_q   <= (op_sel == OP_MOD);
              sp_hold <= sp_in - 1'b1;
            end
          end else begin                       // R2 R3 R5
            result <= fast_val;
            wr_en  <= 1'b1;
            done   <= 1'b1;
            sp_out <= op_pops(op_sel) ? sp_in - 1'b1 : sp_in;
          end
        end
        S_DIV: if (div_fin) begin
          result <= mod_q ? remd : quot;
          sp_out <= sp_hold;
          wr_en  <= 1'b1;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stkop_chk.sv
module stkop_chk
  import stkop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SP_W   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [OP_W-1:0]   op_sel,
  input logic [SP_W-1:0]   sp_in,
  input logic [DATA_W-1:0] top_word,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [SP_W-1:0]   sp_out,
  input logic              wr_en,
  input logic              ret_flag,
  input logic              div_zero,
  input logic              illegal
);
  logic            busy_q, ok_q, acc;
  logic [OP_W-1:0] lat_op;
  logic [SP_W-1:0] lat_sp;
  logic            lat_dz;
  logic [15:0]     wait_cnt;

  assign acc = start && (!busy_q || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      ok_q     <= 1'b0;
      lat_op   <= '0;
      lat_sp   <= '0;
      lat_dz   <= 1'b0;
      wait_cnt <= '0;
    end else begin
      ok_q <= 1'b1;
      if (acc) begin
        busy_q   <= 1'b1;
        lat_op   <= op_sel;
        lat_sp   <= sp_in;
        lat_dz   <= op_divlike(op_sel) && (top_word == '0);
        wait_cnt <= '0;
      end else begin
        if (done) busy_q <= 1'b0;
        if (busy_q && !done) wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  p_fast_done_r9: assert property (@(posedge clk) disable iff (rst)
    acc && (!op_divlike(op_sel) || top_word == '0) |=> done);

  p_div_bound_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> wait_cnt <= 16'(DATA_W + 2));

  p_one_kind_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, ret_flag, div_zero, illegal}));

  p_pulse_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en || ret_flag || div_zero || illegal) |-> done);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ok_q && !wr_en |-> $stable(result));

  p_pop_sp_r2: assert property (@(posedge clk) disable iff (rst)
    done && wr_en && op_pops(lat_op) |-> sp_out == SP_W'(lat_sp - 1'b1));

  p_keep_sp_r3: assert property (@(posedge clk) disable iff (rst)
    done && !(wr_en && op_pops(lat_op)) |-> sp_out == lat_sp);

  p_zero_div_r6: assert property (@(posedge clk) disable iff (rst)
    done && lat_dz |-> div_zero);

  p_ret_r7: assert property (@(posedge clk) disable iff (rst)
    done && lat_op == OP_RTN |-> ret_flag);

  p_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    done && !op_legal(lat_op) |-> illegal);
endmodule

bind stack_op_unit stkop_chk #(.DATA_W(DATA_W), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .sp_in(sp_in),
  .top_word(top_word), .done(done), .result(result), .sp_out(sp_out),
  .wr_en(wr_en), .ret_flag(ret_flag), .div_zero(div_zero), .illegal(illegal)
);

// File: tb/sim_stack_op_unit.sv
module sim_stack_op_unit;
  localparam int DW = 8;
  localparam int SW = 6;
  localparam logic [1:0] K_W = 2'd0, K_RET = 2'd1, K_DZ = 2'd2, K_ILL = 2'd3;

  typedef struct packed {
    logic [3:0]    op;
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    logic [SW-1:0] sp;
    logic [1:0]    kind;
    logic [DW-1:0] res;
    logic [SW-1:0] sp_exp;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  8'h05, 8'h07, 6'd10, K_W,   8'h0C, 6'd9},
    '{4'd2,  8'h64, 8'h64, 6'd10, K_W,   8'hC8, 6'd9},
    '{4'd2,  8'h01, 8'h01, 6'd0,  K_W,   8'h02, 6'd63},
    '{4'd3,  8'h03, 8'h0A, 6'd10, K_W,   8'hF9, 6'd9},
    '{4'd4,  8'hFD, 8'h07, 6'd10, K_W,   8'hEB, 6'd9},
    '{4'd4,  8'h10, 8'h14, 6'd10, K_W,   8'h40, 6'd9},
    '{4'd1,  8'h00, 8'h05, 6'd10, K_W,   8'hFB, 6'd10},
    '{4'd1,  8'h00, 8'h80, 6'd10, K_W,   8'h80, 6'd10},
    '{4'd6,  8'h00, 8'h07, 6'd10, K_W,   8'h01, 6'd10},
    '{4'd6,  8'h00, 8'hFD, 6'd10, K_W,   8'h01, 6'd10},
    '{4'd6,  8'h00, 8'h04, 6'd10, K_W,   8'h00, 6'd10},
    '{4'd5,  8'h07, 8'h02, 6'd10, K_W,   8'h03, 6'd9},
    '{4'd5,  8'hF9, 8'h02, 6'd10, K_W,   8'hFD, 6'd9},
    '{4'd5,  8'h07, 8'hFE, 6'd10, K_W,   8'hFD, 6'd9},
    '{4'd7,  8'hF9, 8'h02, 6'd10, K_W,   8'hFF, 6'd9},
    '{4'd7,  8'h07, 8'hFE, 6'd10, K_W,   8'h01, 6'd9},
    '{4'd5,  8'h80, 8'hFF, 6'd10, K_W,   8'h80, 6'd9},
    '{4'd7,  8'h05, 8'h07, 6'd10, K_W,   8'h05, 6'd9},
    '{4'd5,  8'h05, 8'h00, 6'd10, K_DZ,  8'h00, 6'd10},
    '{4'd7,  8'h05, 8'h00, 6'd10, K_DZ,  8'h00, 6'd10},
    '{4'd8,  8'h05, 8'h05, 6'd10, K_W,   8'h01, 6'd9},
    '{4'd8,  8'h05, 8'h06, 6'd10, K_W,   8'h00, 6'd9},
    '{4'd9,  8'h05, 8'h05, 6'd10, K_W,   8'h00, 6'd9},
    '{4'd10, 8'hFF, 8'h01, 6'd10, K_W,   8'h01, 6'd9},
    '{4'd10, 8'h01, 8'hFF, 6'd10, K_W,   8'h00, 6'd9},
    '{4'd11, 8'h03, 8'h03, 6'd10, K_W,   8'h01, 6'd9},
    '{4'd12, 8'h02, 8'hFB, 6'd10, K_W,   8'h01, 6'd9},
    '{4'd12, 8'hFB, 8'h02, 6'd10, K_W,   8'h00, 6'd9},
    '{4'd0,  8'h11, 8'h22, 6'd10, K_RET, 8'h00, 6'd10},
    '{4'd13, 8'h11, 8'h22, 6'd10, K_ILL, 8'h00, 6'd10},
    '{4'd15, 8'h11, 8'h22, 6'd10, K_ILL, 8'h00, 6'd10}
  };

  logic          clk = 1'b0;
  logic          rst, start;
  logic [3:0]    op_sel;
  logic [SW-1:0] sp_in, sp_out;
  logic [DW-1:0] top_word, next_word, result;
  logic          done, wr_en, ret_flag, div_zero, illegal;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  stack_op_unit #(.DATA_W(DW), .SP_W(SW)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .sp_in(sp_in),
    .top_word(top_word), .next_word(next_word), .done(done), .result(result),
    .sp_out(sp_out), .wr_en(wr_en), .ret_flag(ret_flag), .div_zero(div_zero),
    .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op, input logic [1:0] k);
    if (k == K_DZ) return "R6";
    case (op)
      4'd0:                      return "R7";
      4'd1, 4'd6:                return "R3";
      4'd2, 4'd3, 4'd4:          return "R2";
      4'd5, 4'd7:                return "R4";
      4'd8, 4'd9, 4'd10, 4'd11,
      4'd12:                     return "R5";
      default:                   return "R8";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [DW-1:0] lo,
                        input logic [DW-1:0] hi, input logic [SW-1:0] sp,
                        output int cyc);
    op_sel = op; next_word = lo; top_word = hi; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #2000000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] last_res;
    int cyc;
    int n_done;
    rst = 1'b1; start = 1'b0; op_sel = '0; sp_in = '0;
    top_word = '0; next_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({done, wr_en, ret_flag, div_zero, illegal} == 5'b0 && result == '0 && sp_out == '0,
        "R1", "reset outputs", {done, wr_en, ret_flag, div_zero, illegal, result, sp_out}, 32'h0);
    last_res = '0;

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  fl_exp;
      logic [31:0] got, exp;
      run_op(TBL[i].op, TBL[i].lo, TBL[i].hi, TBL[i].sp, cyc);
      fl_exp = (TBL[i].kind == K_W)   ? 4'b1000 :
               (TBL[i].kind == K_RET) ? 4'b0100 :
               (TBL[i].kind == K_DZ)  ? 4'b0010 : 4'b0001;
      if (TBL[i].kind == K_W) last_res = TBL[i].res;
      got = {done, wr_en, ret_flag, div_zero, illegal, 3'b0, sp_out, 2'b0, result};
      exp = {1'b1, fl_exp, 3'b0, TBL[i].sp_exp, 2'b0, last_res};
      chk(got == exp, req_of(TBL[i].op, TBL[i].kind), $sformatf("vector %0d", i), got, exp);
      // R9 latency
      if (TBL[i].kind == K_W && (TBL[i].op == 4'd5 || TBL[i].op == 4'd7))
        chk(cyc <= DW + 2, "R9", $sformatf("divide latency vec %0d", i), cyc, DW + 2);
      else
        chk(cyc == 1, "R9", $sformatf("single-cycle latency vec %0d", i), cyc, 1);
    end

    // R11: pulses drop and outputs hold
    run_op(4'd2, 8'h03, 8'h04, 6'd7, cyc);
    @(negedge clk);
    chk(!done && !wr_en && result == 8'h07 && sp_out == 6'd6, "R11", "hold after done",
        {done, wr_en, result, sp_out}, {2'b00, 8'h07, 6'd6});
    repeat (3) @(negedge clk);
    chk(!done && result == 8'h07 && sp_out == 6'd6, "R11", "hold while idle",
        {done, result, sp_out}, {1'b0, 8'h07, 6'd6});

    // R10: starts during a division are ignored
    op_sel = 4'd5; next_word = 8'h64; top_word = 8'h07; sp_in = 6'd20; start = 1'b1;
    @(negedge clk);
    op_sel = 4'd2; next_word = 8'h01; top_word = 8'h01; sp_in = 6'd5;
    n_done = 0;
    for (int c = 0; c < 3; c++) begin
      if (done) n_done++;
      @(negedge clk);
    end
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(n_done == 0 && result == 8'h0E && sp_out == 6'd19 && wr_en, "R10",
        "division result survives extra starts", {n_done[7:0], result, sp_out},
        {8'd0, 8'h0E, 6'd19});
    n_done = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (done) n_done++;
    end
    chk(n_done == 0 && result == 8'h0E, "R10", "no extra completion",
        {n_done[7:0], result}, {8'd0, 8'h0E});
    run_op(4'd2, 8'h01, 8'h01, 6'd5, cyc);
    chk(done && result == 8'h02 && sp_out == 6'd4 && cyc == 1, "R10",
        "accepts again when idle", {result, sp_out}, {8'h02, 6'd4});

    // R11: flag pulse leaves result untouched and lasts one cycle
    run_op(4'd14, 8'h00, 8'h00, 6'd3, cyc);
    chk(illegal && !wr_en && result == 8'h02, "R11", "flag keeps result",
        {illegal, wr_en, result}, {2'b10, 8'h02});
    @(negedge clk);
    chk(!illegal && !done, "R11", "flag is a pulse", {illegal, done}, 2'b00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule